// File: doc/BRIEF.md
# SPI Register Access Port

This block is a serial slave through which a host reads and writes a bank of 24-bit registers one word at a time. Every transaction is framed by an active-low select. While the select is low, the host sends an 8-bit command that holds the direction and a 6-bit word address. Three data bytes follow, most significant byte first. On a read, the block fetches the addressed word from the register bank and shifts it out. On a write, it collects the incoming word and hands it to the bank once the frame is complete.

The serial pins are sampled in the system clock domain. Each pin passes through a two-flop synchronizer, and clock edges are detected in the system domain. The system clock therefore has to run several times faster than the serial clock, which has high and low phases of at least 250 ns. The host may stop the serial clock at any point while the select stays low. Word addresses are the byte addresses of the register map divided by three. The register bank side is a plain synchronous port: a one-cycle read strobe with read data expected one cycle later, and a one-cycle write strobe with address and data.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, `spi_miso_o`, `reg_rd_o`, `reg_wr_o` and `reg_addr_o` are all zero.
- R2: The first 8 bits after the select falls form the command, sent MSB first. Bit 7 is the direction (1 = read, 0 = write), bits 6:1 are the word address, and bit 0 is ignored. The decoded address appears on `reg_addr_o` for the bank access.
- R3: A read command produces exactly one single-cycle `reg_rd_o` pulse. `reg_rdata_i` is taken one system cycle after that pulse and shifted out on `spi_miso_o` MSB first. Bit 23 is valid after the serial-clock falling edge that ends the command, and each later falling edge presents the next bit, so the host samples on rising edges.
- R4: A write command is followed by 24 data bits, MSB first. After the 32nd rising edge, one single-cycle `reg_wr_o` pulse carries the address and the received word.
- R5: If the select rises before the 32nd rising edge, no write takes place and the register keeps its old value.
- R6: The serial clock may stay high or low for any length of time while the select is low, and the transfer completes unchanged.
- R7: Rising edges after the 32nd within one select window are ignored. They cause no further write, and `spi_miso_o` stays low.
- R8: `spi_miso_o` is low while the select is high and throughout the data phase of a write.
- R9: `reg_rd_o` and `reg_wr_o` are never high together. A write transaction produces no read strobe, and a read transaction produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_csn_i | input | 1 | Serial select, active low |
| spi_sck_i | input | 1 | Serial clock, idles low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| reg_addr_o | output | ADDR_W (6) | Word address to register bank |
| reg_rd_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | DATA_W (24) | Read data, valid one cycle after the strobe |
| reg_wr_o | output | 1 | Write strobe, one cycle |
| reg_wdata_o | output | DATA_W (24) | Write data |

## Verification
The hardest cases to reach from the pins are frames that are cut short or overrun: a select that rises after 20 or 31 rising edges, and a select window with 40 clock pulses. The bench drives these explicitly and then reads the same word back to show that nothing was committed. Clock stalls are placed inside the command byte, next to the command/data boundary, and deep in the data phase, with the clock held in each of its two levels. A full read sweep over all 64 addresses and a strided write-and-readback sweep exercise every address bit against arithmetic data patterns.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_DATA_W = 24;
  localparam int DEF_SYNC   = 2;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[s] <= RST_VAL;
        else         st[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[s] <= RST_VAL;
        else         st[s] <= st[s-1];
      end
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_front.sv
module spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic spi_csn_i,
  input  logic spi_sck_i,
  input  logic spi_mosi_i,
  output logic cs_act_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic mosi_o
);
  logic [2:0] pins_s;
  logic       sck_q;

  spi_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_csn_i, spi_sck_i, spi_mosi_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= pins_s[1];
  end

  assign cs_act_o   = ~pins_s[2];
  assign sck_rise_o = cs_act_o &  pins_s[1] & ~sck_q;
  assign sck_fall_o = cs_act_o & ~pins_s[1] &  sck_q;
  assign mosi_o     = pins_s[0];
endmodule

// File: rtl/spi_rx.sv
module spi_rx #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sck_rise_i,
  input  logic              mosi_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cmd_done_o,
  output logic [CMD_W-2:0]  cmd_o,
  output logic              word_done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [DATA_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  assign take = sck_rise_i && (cnt_q != CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!cs_act_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[DATA_W-3:0], mosi_i};
    end
  end

  // command bit 0 is reserved and never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_done_o  <= 1'b0;
      word_done_o <= 1'b0;
      cmd_o       <= '0;
      word_o      <= '0;
    end else begin
      cmd_done_o  <= take && (cnt_q == CNT_CMD);
      word_done_o <= take && (cnt_q == CNT_LAST);
      if (take && (cnt_q == CNT_CMD))  cmd_o  <= sh_q[CMD_W-2:0];
      if (take && (cnt_q == CNT_LAST)) word_o <= {sh_q, mosi_i};
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  p_cmd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o);
  p_cnt_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sck_fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              miso_o
);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W + DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic              in_data;

  assign in_data = (cnt_i >= CNT_DATA) && (cnt_i < CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      miso_o <= 1'b0;
    end else if (!cs_act_i) begin
      sh_q   <= '0;
      miso_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= load_data_i;
    end else if (sck_fall_i) begin
      if (in_data) begin
        miso_o <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
      end else begin
        miso_o <= 1'b0;
      end
    end
  end

  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_o);
  p_tail_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_FULL && sck_fall_i) |=> !miso_o);
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_csn_i,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  localparam int CMD_W   = ADDR_W + 2;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);

  logic              cs_act, sck_rise, sck_fall, mosi_s;
  logic [CNT_W-1:0]  cnt;
  logic              cmd_done, word_done;
  logic [CMD_W-2:0]  cmd;
  logic [DATA_W-1:0] word;
  dir_e              dir_q;
  logic              rd_q, rd_d1, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .spi_csn_i (spi_csn_i),
    .spi_sck_i (spi_sck_i),
    .spi_mosi_i(spi_mosi_i),
    .cs_act_o  (cs_act),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall),
    .mosi_o    (mosi_s)
  );

  spi_rx #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sck_rise_i (sck_rise),
    .mosi_i     (mosi_s),
    .cnt_o      (cnt),
    .cmd_done_o (cmd_done),
    .cmd_o      (cmd),
    .word_done_o(word_done),
    .word_o     (word)
  );

  // command decode and bank strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= DIR_WRITE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      rd_d1   <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      rd_d1 <= rd_q;
      rd_q  <= cmd_done && cmd[CMD_W-2];
      wr_q  <= word_done && (dir_q == DIR_WRITE);
      if (cmd_done) begin
        dir_q  <= dir_e'(cmd[CMD_W-2]);
        addr_q <= cmd[CMD_W-3:0];
      end
      if (word_done && (dir_q == DIR_WRITE)) wdata_q <= word;
    end
  end

  spi_tx #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sck_fall_i (sck_fall),
    .cnt_i      (cnt),
    .load_i     (rd_d1),
    .load_data_i(reg_rdata_i),
    .miso_o     (spi_miso_o)
  );

  assign reg_addr_o  = addr_q;
  assign reg_rd_o    = rd_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;

  p_rd_wr_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_q && wr_q));
  p_wr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);
  p_rd_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !rd_q);
  p_wr_full_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> ($past(cnt) == CNT_FULL));
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && cnt > CNT_CMD) |-> $stable(addr_q));
endmodule

// File: tb/test_spi_reg_port.sv
`timescale 1ns/1ps
module test_spi_reg_port;
  localparam int HALF  = 260;
  localparam int STALL = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic        miso;
  logic [5:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [23:0] reg_rdata, reg_wdata;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [5:0]  last_wa, last_ra;
  logic [23:0] last_wd;
  logic [23:0] rx_word;
  logic        extra_hi, wmiso_hi;
  logic [23:0] mem [64];

  always #10 clk = ~clk;

  spi_reg_port i_spi_reg_port (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .spi_csn_i  (csn),
    .spi_sck_i  (sck),
    .spi_mosi_i (mosi),
    .spi_miso_o (miso),
    .reg_addr_o (reg_addr),
    .reg_rd_o   (reg_rd),
    .reg_rdata_i(reg_rdata),
    .reg_wr_o   (reg_wr),
    .reg_wdata_o(reg_wdata)
  );

  function automatic logic [23:0] pat(int a);
    return 24'(a * 24'h2F1D3) ^ 24'hC35A96;
  endfunction

  function automatic logic [23:0] wpat(int a);
    return 24'(a * 24'h1357B + 24'h0F0F0F) ^ 24'h800001;
  endfunction

  // register bank model and strobe monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt  <= wr_cnt + 1;
        last_wa <= reg_addr;
        last_wd <= reg_wdata;
      end
      if (reg_rd) begin
        reg_rdata <= mem[reg_addr];
        rd_cnt  <= rd_cnt + 1;
        last_ra <= reg_addr;
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(bit rw, int addr, logic [23:0] wd, int nbits, int stall_bit);
    logic [31:0] frame;
    frame = {rw, 6'(addr), 1'b0, wd};
    rx_word = '0; extra_hi = 1'b0; wmiso_hi = 1'b0;
    @(negedge clk);
    csn = 1'b0;
    #(HALF);
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 32) ? frame[31-b] : 1'b0;
      #(HALF);
      if (b >= 8 && b < 32) begin
        rx_word = {rx_word[22:0], miso};
        if (!rw && miso) wmiso_hi = 1'b1;
      end
      if (b >= 32 && miso) extra_hi = 1'b1;
      sck = 1'b1;
      if (b == stall_bit) #(STALL);
      #(HALF);
      sck = 1'b0;
      if (b == stall_bit) #(STALL);
    end
    #(HALF);
    csn = 1'b1;
    #(400);
  endtask

  task automatic do_read(int a, logic [23:0] exp, int nbits, int stall_bit, string req);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    xfer(1'b1, a, 24'h0, nbits, stall_bit);
    chk(req, 32'(rx_word), 32'(exp));
    chk("R3 one read strobe", rd_cnt, r0 + 1);
    chk("R2 read address", 32'(last_ra), 32'(a));
    chk("R9 no write on read", wr_cnt, w0);
    chk("R8 miso idle", 32'(miso), 0);
  endtask

  initial begin
    int w0, r0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 miso reset", 32'(miso), 0);
    chk("R1 rd reset", 32'(reg_rd), 0);
    chk("R1 wr reset", 32'(reg_wr), 0);
    chk("R1 addr reset", 32'(reg_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int a = 0; a < 64; a++) do_read(a, pat(a), 32, -1, "R3 read data");

    for (int a = 1; a < 64; a += 4) begin
      w0 = wr_cnt; r0 = rd_cnt;
      xfer(1'b0, a, wpat(a), 32, -1);
      chk("R4 one write strobe", wr_cnt, w0 + 1);
      chk("R4 write address", 32'(last_wa), 32'(a));
      chk("R4 write data", 32'(last_wd), 32'(wpat(a)));
      chk("R9 no read on write", rd_cnt, r0);
      chk("R8 miso low in write", 32'(wmiso_hi), 0);
      do_read(a, wpat(a), 32, -1, "R2 readback");
    end

    // aborted writes
    w0 = wr_cnt;
    xfer(1'b0, 2, 24'h5A5A5A, 20, -1);
    chk("R5 abort at 20", wr_cnt, w0);
    xfer(1'b0, 2, 24'h5A5A5A, 31, -1);
    chk("R5 abort at 31", wr_cnt, w0);
    do_read(2, pat(2), 32, -1, "R5 register kept");

    // stalled clocks
    w0 = wr_cnt;
    xfer(1'b0, 3, 24'h3C69A5, 32, 5);
    chk("R6 write stall in command", wr_cnt, w0 + 1);
    do_read(3, 24'h3C69A5, 32, 12, "R6 read stall in data");
    xfer(1'b0, 3, 24'hE1D2C3, 32, 20);
    chk("R6 write stall in data", 32'(last_wd), 32'hE1D2C3);
    do_read(3, 24'hE1D2C3, 32, 7, "R6 read stall at boundary");

    // overrun frames
    w0 = wr_cnt;
    xfer(1'b0, 7, 24'h00FFF0, 40, -1);
    chk("R7 single write on overrun", wr_cnt, w0 + 1);
    chk("R7 overrun write data", 32'(last_wd), 32'h00FFF0);
    do_read(7, 24'h00FFF0, 40, -1, "R7 overrun read data");
    chk("R7 miso low past frame", 32'(extra_hi), 0);
    do_read(63, wpat(61) == 24'h0 ? 24'h0 : pat(63), 32, -1, "R3 top address");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule